// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block produces the two comparison strobes that a phase-frequency detector needs in an integer-N synthesizer. Every clock edge of `clk` stands for one cycle of the fast oscillator input. A modelled dual-modulus prescaler divides that input by P+1 while a swallow count is non-zero, and by P after that. A main count decides how many prescaler periods make up one output period. The feedback strobe therefore repeats every B·P + A input cycles. A second, independent counter divides the reference strobe `ref_en` by R.

Software-side logic presents a new setting (swallow count, main count, modulus pair and reference ratio) together with a one-cycle `cfg_load`. A setting that the swallow scheme cannot realise is refused and flagged. A setting that is accepted waits in a shadow copy and is applied only when the running period ends, so no period is ever cut short. The parameter `HIGH_BAND` selects which family of modulus pairs the prescaler offers.

Top module: `pswd_divider`

## Requirements
- R1: With swallow count A, main count B and base modulus P active, `fb_pulse` is high for exactly one cycle, and consecutive pulses are B·P + A clock edges apart. The first pulse after reset comes on the N-th edge after `rst` falls.
- R2: `cfg_pair` = 0 selects P = 8 (P = 32 when `HIGH_BAND` = 1), and `cfg_pair` = 1 selects P = 16 (P = 64 when `HIGH_BAND` = 1). Within a period, the first A prescaler periods last P+1 input cycles.
- R3: A load with `cfg_b` = 0 or `cfg_b` < `cfg_a` sets `cfg_invalid` on the next cycle and changes neither ratio. The next accepted load clears `cfg_invalid`.
- R4: An accepted load changes the feedback ratio only at the next feedback period boundary, and the period that is running completes with the old setting. If several loads arrive before a boundary, the last one wins.
- R5: `ref_pulse` fires once every R `ref_en` strobes, in the cycle after the R-th strobe is sampled. An R of 0 or 1 gives one pulse per strobe.
- R6: A new R takes effect only at the next reference boundary. Up to the 14-bit maximum of 16383 is supported.
- R7: A synchronous `rst` restores the default setting (A=1, B=2, pair 0, R=4), discards pending loads, clears `cfg_invalid` and holds both strobes low. Both dividers restart from the beginning of a period.
- R8: The edge settings A = 0, A = B, and the widest A of 63 divide correctly.
- R9: The reference counter advances only on cycles with `ref_en` high, and `ref_pulse` only follows a sampled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One edge per fast input cycle |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | One reference input cycle |
| cfg_load | input | 1 | Present a new setting this cycle |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 11 | Main count B |
| cfg_pair | input | 1 | Modulus pair select |
| cfg_r | input | 14 | Reference ratio R |
| fb_pulse | output | 1 | Divided feedback strobe |
| ref_pulse | output | 1 | Divided reference strobe |
| cfg_invalid | output | 1 | Last load was refused |

## Verification
The bench builds the block with `HIGH_BAND` = 0 and the default setting A=1, B=2, R=4. This gives 17-cycle periods at once, so reset timing and many boundaries are covered early in the run. The 8/9 and 16/17 pairs make the 2700 ratio (P=16, B=168, A=12) reachable in a few thousand cycles, together with the swallow extremes A = 0, A = B and A = 63. With the 14-bit reference width, the largest R of 16383 can be run to a full period with a strobe on every cycle. A sparse strobe pattern shows that the counter pauses between strobes.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

    typedef enum logic {
        PAIR_LOW  = 1'b0,
        PAIR_HIGH = 1'b1
    } pair_sel_e;

    // base modulus P of the selected pair; the prescaler also offers P+1
    function automatic int unsigned base_mod(bit high_band, pair_sel_e sel);
        if (high_band) return (sel == PAIR_HIGH) ? 64 : 32;
        return (sel == PAIR_HIGH) ? 16 : 8;
    endfunction

endpackage

// File: rtl/pswd_shadow.sv
module pswd_shadow
    import pswd_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 11,
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  pair_sel_e      sel_i,
    input  logic [R_W-1:0] r_i,
    input  logic           fb_bnd_i,
    input  logic           ref_bnd_i,
    output logic           fb_pend_o,
    output logic [A_W-1:0] a_o,
    output logic [B_W-1:0] b_o,
    output pair_sel_e      sel_o,
    output logic           ref_pend_o,
    output logic [R_W-1:0] r_o,
    output logic           invalid_o
);

    typedef struct packed {
        logic           fb_v;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        pair_sel_e      sel;
        logic           ref_v;
        logic [R_W-1:0] r;
        logic           inv;
    } shadow_t;

    shadow_t st_d, st_q;
    logic    bad_w;

    // the swallow scheme needs at least one main period and B >= A
    assign bad_w = (b_i == '0) || (b_i < B_W'(a_i));

    always_comb begin
        st_d = st_q;
        if (fb_bnd_i)  st_d.fb_v  = 1'b0;
        if (ref_bnd_i) st_d.ref_v = 1'b0;
        if (load_i) begin
            if (bad_w) begin
                st_d.inv = 1'b1;
            end else begin
                st_d.inv   = 1'b0;
                st_d.fb_v  = 1'b1;
                st_d.a     = a_i;
                st_d.b     = b_i;
                st_d.sel   = sel_i;
                st_d.ref_v = 1'b1;
                st_d.r     = r_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fb_pend_o  = st_q.fb_v;
    assign a_o        = st_q.a;
    assign b_o        = st_q.b;
    assign sel_o      = st_q.sel;
    assign ref_pend_o = st_q.ref_v;
    assign r_o        = st_q.r;
    assign invalid_o  = st_q.inv;

    // a refused load never arms the shadow copy
    assert_refused_not_armed_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && bad_w && !st_q.fb_v) |=> !st_q.fb_v);

    // an armed shadow copy holds a realisable setting
    assert_armed_is_valid_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.fb_v |-> (st_q.b != '0 && st_q.b >= B_W'(st_q.a)));

endmodule

// File: rtl/pswd_fb_div.sv
module pswd_fb_div
    import pswd_pkg::*;
#(
    parameter int          A_W       = 6,
    parameter int          B_W       = 11,
    parameter bit          HIGH_BAND = 1'b0,
    parameter int unsigned DEF_A     = 1,
    parameter int unsigned DEF_B     = 2,
    parameter pair_sel_e   DEF_SEL   = PAIR_LOW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pend_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  pair_sel_e      sel_i,
    output logic           bnd_o,
    output logic           pulse_o
);

    localparam int P_MAX = HIGH_BAND ? 64 : 16;
    localparam int PRE_W = $clog2(P_MAX + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;   // input cycles left in this prescaler period, minus one
        logic [A_W-1:0]   swal;  // prescaler periods still at P+1
        logic [B_W-1:0]   main;  // prescaler periods left in this output period
        logic [A_W-1:0]   a;
        logic [B_W-1:0]   b;
        pair_sel_e        sel;
        logic             pulse;
    } fb_t;

    fb_t fb_d, fb_q;
    logic [A_W-1:0] swal_nx;

    function automatic logic [PRE_W-1:0] start_pre(logic [A_W-1:0] swal, pair_sel_e sel);
        int unsigned m;
        m = base_mod(HIGH_BAND, sel);
        return (swal != '0) ? PRE_W'(m) : PRE_W'(m - 1);
    endfunction

    assign bnd_o   = (fb_q.pre == '0) && (fb_q.main == B_W'(1));
    assign swal_nx = (fb_q.swal != '0) ? fb_q.swal - 1'b1 : fb_q.swal;

    always_comb begin
        fb_d       = fb_q;
        fb_d.pulse = 1'b0;
        if (fb_q.pre != '0) begin
            fb_d.pre = fb_q.pre - 1'b1;
        end else if (bnd_o) begin
            fb_d.pulse = 1'b1;
            if (pend_i) begin
                fb_d.a   = a_i;
                fb_d.b   = b_i;
                fb_d.sel = sel_i;
            end
            fb_d.swal = fb_d.a;
            fb_d.main = fb_d.b;
            fb_d.pre  = start_pre(fb_d.a, fb_d.sel);
        end else begin
            fb_d.swal = swal_nx;
            fb_d.main = fb_q.main - 1'b1;
            fb_d.pre  = start_pre(swal_nx, fb_q.sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q.a     <= A_W'(DEF_A);
            fb_q.b     <= B_W'(DEF_B);
            fb_q.sel   <= DEF_SEL;
            fb_q.swal  <= A_W'(DEF_A);
            fb_q.main  <= B_W'(DEF_B);
            fb_q.pre   <= start_pre(A_W'(DEF_A), DEF_SEL);
            fb_q.pulse <= 1'b0;
        end else begin
            fb_q <= fb_d;
        end
    end

    assign pulse_o = fb_q.pulse;

    assert_main_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        fb_q.main != '0);

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        fb_q.pulse |=> !fb_q.pulse);

    assert_swallow_within_main_R8: assert property (@(posedge clk) disable iff (rst)
        B_W'(fb_q.swal) <= fb_q.main);

    assert_pre_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        fb_q.pre <= PRE_W'(base_mod(HIGH_BAND, fb_q.sel)));

endmodule

// File: rtl/pswd_ref_div.sv
module pswd_ref_div #(
    parameter int          R_W   = 14,
    parameter int unsigned DEF_R = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_en_i,
    input  logic           pend_i,
    input  logic [R_W-1:0] r_i,
    output logic           bnd_o,
    output logic           pulse_o
);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic [R_W-1:0] r;
        logic           pulse;
    } rd_t;

    rd_t rd_d, rd_q;
    logic last_w;

    // ratios 0 and 1 both pass every strobe through
    assign last_w = (rd_q.r < R_W'(2)) ? (rd_q.cnt == '0) : (rd_q.cnt == rd_q.r - 1'b1);
    assign bnd_o  = ref_en_i && last_w;

    always_comb begin
        rd_d       = rd_q;
        rd_d.pulse = 1'b0;
        if (ref_en_i) begin
            if (last_w) begin
                rd_d.pulse = 1'b1;
                rd_d.cnt   = '0;
                if (pend_i) rd_d.r = r_i;
            end else begin
                rd_d.cnt = rd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q.cnt   <= '0;
            rd_q.r     <= R_W'(DEF_R);
            rd_q.pulse <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign pulse_o = rd_q.pulse;

    assert_pulse_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        rd_q.pulse |-> $past(ref_en_i));

    assert_count_held_R9: assert property (@(posedge clk) disable iff (rst)
        !ref_en_i |=> $stable(rd_q.cnt));

    assert_count_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_q.r >= R_W'(2)) |-> (rd_q.cnt < rd_q.r));

endmodule

// File: rtl/pswd_divider.sv
module pswd_divider
    import pswd_pkg::*;
#(
    parameter int          A_W       = 6,
    parameter int          B_W       = 11,
    parameter int          R_W       = 14,
    parameter bit          HIGH_BAND = 1'b0,
    parameter int unsigned DEF_A     = 1,
    parameter int unsigned DEF_B     = 2,
    parameter bit          DEF_PAIR  = 1'b0,
    parameter int unsigned DEF_R     = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_en,
    input  logic           cfg_load,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    input  logic           cfg_pair,
    input  logic [R_W-1:0] cfg_r,
    output logic           fb_pulse,
    output logic           ref_pulse,
    output logic           cfg_invalid
);

    localparam pair_sel_e DEF_SEL = pair_sel_e'(DEF_PAIR);

    logic           fb_pend, ref_pend, fb_bnd, ref_bnd;
    logic [A_W-1:0] sh_a;
    logic [B_W-1:0] sh_b;
    pair_sel_e      sh_sel;
    logic [R_W-1:0] sh_r;

    pswd_shadow #(.A_W(A_W), .B_W(B_W), .R_W(R_W)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cfg_load),
        .a_i        (cfg_a),
        .b_i        (cfg_b),
        .sel_i      (pair_sel_e'(cfg_pair)),
        .r_i        (cfg_r),
        .fb_bnd_i   (fb_bnd),
        .ref_bnd_i  (ref_bnd),
        .fb_pend_o  (fb_pend),
        .a_o        (sh_a),
        .b_o        (sh_b),
        .sel_o      (sh_sel),
        .ref_pend_o (ref_pend),
        .r_o        (sh_r),
        .invalid_o  (cfg_invalid)
    );

    pswd_fb_div #(
        .A_W(A_W), .B_W(B_W), .HIGH_BAND(HIGH_BAND),
        .DEF_A(DEF_A), .DEF_B(DEF_B), .DEF_SEL(DEF_SEL)
    ) u_fb (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (fb_pend),
        .a_i     (sh_a),
        .b_i     (sh_b),
        .sel_i   (sh_sel),
        .bnd_o   (fb_bnd),
        .pulse_o (fb_pulse)
    );

    pswd_ref_div #(.R_W(R_W), .DEF_R(DEF_R)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .ref_en_i (ref_en),
        .pend_i   (ref_pend),
        .r_i      (sh_r),
        .bnd_o    (ref_bnd),
        .pulse_o  (ref_pulse)
    );

    assert_reset_quiet_R7: assert property (@(posedge clk)
        rst |=> (!fb_pulse && !ref_pulse && !cfg_invalid));

endmodule

// File: tb/tb_pswd_divider.sv
module tb_pswd_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en = 1'b0;
    logic        cfg_load = 1'b0;
    logic [5:0]  cfg_a = '0;
    logic [10:0] cfg_b = '0;
    logic        cfg_pair = 1'b0;
    logic [13:0] cfg_r = '0;
    logic        fb_pulse, ref_pulse, cfg_invalid;

    always #4 clk = ~clk;

    pswd_divider dut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .cfg_load(cfg_load),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_pair(cfg_pair), .cfg_r(cfg_r),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .cfg_invalid(cfg_invalid)
    );

    int    checks = 0, fails = 0, cyc = 0, ref_mode = 0;
    bit    started = 0, done = 0;
    string tag = "R7";

    // behavioural reference: input cycles since the last boundary
    int m_a, m_b, m_p, m_r, cnt, rcnt, p_a, p_b, p_p, p_r;
    bit pend, rpend, e_fb, e_ref, e_inv;

    function automatic int pval(int p);
        return (p != 0) ? 16 : 8;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_a = 1; m_b = 2; m_p = 0; m_r = 4;
            cnt = 0; rcnt = 0; pend = 0; rpend = 0;
            e_fb = 0; e_ref = 0; e_inv = 0;
        end else begin
            cnt++;
            e_fb = 0;
            if (cnt == m_b * pval(m_p) + m_a) begin
                e_fb = 1; cnt = 0;
                if (pend) begin m_a = p_a; m_b = p_b; m_p = p_p; pend = 0; end
            end
            e_ref = 0;
            if (ref_en) begin
                rcnt++;
                if (rcnt >= ((m_r < 2) ? 1 : m_r)) begin
                    e_ref = 1; rcnt = 0;
                    if (rpend) begin m_r = p_r; rpend = 0; end
                end
            end
            if (cfg_load) begin
                if (cfg_b == 0 || int'(cfg_b) < int'(cfg_a)) e_inv = 1;
                else begin
                    e_inv = 0; pend = 1; rpend = 1;
                    p_a = cfg_a; p_b = cfg_b; p_p = cfg_pair; p_r = cfg_r;
                end
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        ref_en <= (ref_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (started && !done) begin
            checks += 3;
            if (fb_pulse !== e_fb) begin
                fails++;
                $display("FAIL %s fb_pulse actual %0b expected %0b at cycle %0d", tag, fb_pulse, e_fb, cyc);
            end
            if (ref_pulse !== e_ref) begin
                fails++;
                $display("FAIL %s ref_pulse actual %0b expected %0b at cycle %0d", tag, ref_pulse, e_ref, cyc);
            end
            if (cfg_invalid !== e_inv) begin
                fails++;
                $display("FAIL %s cfg_invalid actual %0b expected %0b at cycle %0d", tag, cfg_invalid, e_inv, cyc);
            end
        end
    end

    task automatic load_cfg(int a, int b, int p, int r);
        @(negedge clk);
        cfg_a = 6'(a); cfg_b = 11'(b); cfg_pair = p[0]; cfg_r = 14'(r);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tag = "R7"; run(3); rst = 1'b0;
        tag = "R1"; run(120);
        tag = "R2"; load_cfg(3, 5, 1, 4); run(400);
        tag = "R8"; load_cfg(0, 4, 0, 4); run(200);
        load_cfg(7, 7, 0, 4); run(200);
        load_cfg(63, 63, 0, 4); run(1300);
        tag = "R1"; load_cfg(12, 168, 1, 4); run(6000);
        tag = "R3"; load_cfg(5, 2, 0, 9); run(3000);
        load_cfg(0, 0, 1, 9); run(100);
        load_cfg(2, 3, 0, 4); run(100);
        tag = "R4"; run(5); load_cfg(1, 3, 0, 4); load_cfg(4, 5, 1, 4); run(300);
        tag = "R5"; load_cfg(1, 2, 0, 0); run(60);
        load_cfg(1, 2, 0, 1); run(60);
        tag = "R9"; ref_mode = 1; load_cfg(1, 2, 0, 7); run(300);
        tag = "R6"; ref_mode = 0; load_cfg(1, 2, 0, 16383); run(16600);
        tag = "R7"; load_cfg(2, 3, 1, 5); rst = 1'b1; run(2); rst = 1'b0; run(200);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule